// File: doc/BRIEF.md
# Paged Processor Access Port for a Time-Slot Switch

This block connects an asynchronous 8-bit processor bus to the storage of a time-slot switch. The processor sees 64 byte addresses. The lower half of the address space always reaches one page register. The upper half is a 32-entry window onto one of three 256-entry arrays: the received-sample store (read-only), the connection source/message byte store (low store) and the per-channel control store (high store). The page register picks the array and the stream. The five low address bits pick the channel.

The strobes arrive with no relation to the switching clock, so they are brought into that clock domain through a synchronizer. Array reads and writes are issued only in the cycle where the switch schedule raises `svc_slot`, so the serial datapath is never disturbed. A write to the page register is acknowledged as soon as the strobe has been synchronized. Every other access waits for a service slot first. The acknowledge is active low and is held until the processor drops its strobe or chip select. A split option sends every array read to the sample store and every array write to the low store.

Top module: `mpi_paged_port`

## Requirements
- R1: With `addr[5]`=0 the page register is accessed whatever `addr[4:0]` hold. Its fields are: bit 7 split, bit 6 global message (driven on `msg_mode`), bit 5 always reads 0, bits 4:3 array select, bits 2:0 stream.
- R2: With `addr[5]`=1 the access reaches array entry `{stream, addr[4:0]}` on `mem_addr`. The array select codes are 01 for the sample store, 10 for the low store and 11 for the high store.
- R3: The high store keeps 3 bits per entry. Reads from it return 0 in bits 7:3.
- R4: While the split bit is 1, array reads come from the sample store and array writes go to the low store, whatever the select field holds. The high store is never touched in this mode.
- R5: Writes aimed at the sample store, or made with select code 00, are acknowledged and change nothing. Reads with select code 00 return 0.
- R6: An access starts only when `cs_n`=0 and `ds`=1 at the same time. `rw`=1 means read and `rw`=0 means write.
- R7: A page-register write is acknowledged within 4 clock cycles of the strobe. Every other access waits for a service slot and takes at least 5 cycles.
- R8: Array enables are raised only in a cycle with `svc_slot`=1, and never more than one at a time.
- R9: `ack_n` stays low until `cs_n` goes high or `ds` goes low, and then returns high. `rdata_oe` is 1 only while a read is being acknowledged.
- R10: After reset `ack_n`=1, `rdata_oe`=0 and the page register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds | input | 1 | Data strobe, active high, asynchronous |
| rw | input | 1 | 1 read, 0 write |
| addr | input | 6 | Bit 5 picks window, bits 4:0 channel |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| rdata_oe | output | 1 | Enable for the processor data drivers |
| ack_n | output | 1 | Acknowledge, active low (open-drain pull-down) |
| msg_mode | output | 1 | Global message bit of page register |
| svc_slot | input | 1 | Schedule slot reserved for processor access |
| mem_addr | output | 8 | Array entry {stream, channel} |
| mem_wdata | output | 8 | Array write data |
| dm_re | output | 1 | Sample store read enable |
| dm_rdata | input | 8 | Sample store read data (one cycle after enable) |
| cml_re | output | 1 | Low store read enable |
| cml_we | output | 1 | Low store write enable |
| cml_rdata | input | 8 | Low store read data (one cycle after enable) |
| cmh_re | output | 1 | High store read enable |
| cmh_we | output | 1 | High store write enable (uses mem_wdata[2:0]) |
| cmh_rdata | input | 3 | High store read data (one cycle after enable) |

## Verification
Two events can fall in the same cycle here. One is an access waiting for its slot when `svc_slot` rises. The other is a page-register change that moves the window and the routing of the access that follows it. The bench provokes both by issuing back-to-back page writes and array accesses while a free-running slot generator runs at a phase unrelated to the strobes. It judges them by reading back, through the port, the entries each write should and should not have reached. The split mode is covered by showing that a write went to the low store and left the high store untouched, and that a read in the same page came from the sample store.

// File: rtl/mpi_pkg.sv
package mpi_pkg;
    localparam int DATA_W   = 8;
    localparam int STREAM_W = 3;
    localparam int CHAN_W   = 5;
    localparam int ADDR_W   = CHAN_W + 1;
    localparam int MEM_AW   = STREAM_W + CHAN_W;
    localparam int CMH_W    = 3;

    localparam logic [1:0] SEL_DM  = 2'b01;
    localparam logic [1:0] SEL_CML = 2'b10;
    localparam logic [1:0] SEL_CMH = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CAPT,
        ST_ACK
    } state_e;

    typedef enum logic [2:0] {
        TG_NONE,
        TG_CTRL,
        TG_DM,
        TG_CML,
        TG_CMH
    } target_e;
endpackage

// File: rtl/mpi_sync.sv
module mpi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[LAST-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/mpi_decode.sv
module mpi_decode
    import mpi_pkg::*;
(
    input  logic       is_ctrl,
    input  logic       is_rd,
    input  logic       split,
    input  logic [1:0] sel,
    output target_e    tgt
);
    // R4: split overrides the select field; R5: code 00 has no target
    always_comb begin
        if (is_ctrl) begin
            tgt = TG_CTRL;
        end else if (split) begin
            tgt = is_rd ? TG_DM : TG_CML;
        end else begin
            case (sel)
                SEL_DM:  tgt = TG_DM;
                SEL_CML: tgt = TG_CML;
                SEL_CMH: tgt = TG_CMH;
                default: tgt = TG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mpi_paged_port.sv
module mpi_paged_port
    import mpi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ds,
    input  logic                rw,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_oe,
    output logic                ack_n,
    output logic                msg_mode,
    input  logic                svc_slot,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                dm_re,
    input  logic [DATA_W-1:0]   dm_rdata,
    output logic                cml_re,
    output logic                cml_we,
    input  logic [DATA_W-1:0]   cml_rdata,
    output logic                cmh_re,
    output logic                cmh_we,
    input  logic [CMH_W-1:0]    cmh_rdata
);
    localparam int PG_SPLIT = 7;
    localparam int PG_MSG   = 6;
    localparam int PG_GAP   = 5;
    localparam int PG_SEL   = 3;

    typedef struct packed {
        state_e              st;
        logic [DATA_W-1:0]   page;
        logic                rd;
        logic [ADDR_W-1:0]   adr;
        logic [DATA_W-1:0]   wd;
        logic [DATA_W-1:0]   rdat;
    } regs_t;

    regs_t   r_d, r_q;
    logic    cs_s, ds_s, sel_act;
    logic    go;
    target_e tgt;

    // R6: both strobes synchronized; access active on cs_n low with ds high
    mpi_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(~cs_n), .dout(cs_s));
    mpi_sync #(.STAGES(SYNC_STAGES)) u_sync_ds (
        .clk(clk), .rst_n(rst_n), .din(ds), .dout(ds_s));

    assign sel_act = cs_s & ds_s;

    mpi_decode u_dec (
        .is_ctrl(~r_q.adr[ADDR_W-1]),
        .is_rd  (r_q.rd),
        .split  (r_q.page[PG_SPLIT]),
        .sel    (r_q.page[PG_SEL+1:PG_SEL]),
        .tgt    (tgt)
    );

    assign go = (r_q.st == ST_WAIT) && svc_slot;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (sel_act) begin
                    r_d.rd  = rw;
                    r_d.adr = addr;
                    r_d.wd  = wdata;
                    if (!addr[ADDR_W-1] && !rw) begin
                        // R7: page write needs no slot; R1: gap bit not stored
                        r_d.page         = wdata;
                        r_d.page[PG_GAP] = 1'b0;
                        r_d.st           = ST_ACK;
                    end else begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (svc_slot) r_d.st = ST_CAPT;
            end
            ST_CAPT: begin
                if (r_q.rd) begin
                    case (tgt)
                        TG_CTRL: r_d.rdat = r_q.page;
                        TG_DM:   r_d.rdat = dm_rdata;
                        TG_CML:  r_d.rdat = cml_rdata;
                        TG_CMH:  r_d.rdat = {{(DATA_W-CMH_W){1'b0}}, cmh_rdata}; // R3
                        default: r_d.rdat = '0;                                  // R5
                    endcase
                end
                r_d.st = ST_ACK;
            end
            default: begin
                if (!sel_act) r_d.st = ST_IDLE; // R9
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, page: '0, rd: 1'b0, adr: '0, wd: '0, rdat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R2: window address; R8: enables only in the granted slot
    assign mem_addr  = {r_q.page[STREAM_W-1:0], r_q.adr[CHAN_W-1:0]};
    assign mem_wdata = r_q.wd;
    assign dm_re     = go &&  r_q.rd && (tgt == TG_DM);
    assign cml_re    = go &&  r_q.rd && (tgt == TG_CML);
    assign cml_we    = go && !r_q.rd && (tgt == TG_CML);
    assign cmh_re    = go &&  r_q.rd && (tgt == TG_CMH);
    assign cmh_we    = go && !r_q.rd && (tgt == TG_CMH);

    assign ack_n    = (r_q.st != ST_ACK);
    assign rdata_oe = (r_q.st == ST_ACK) && r_q.rd;
    assign rdata    = r_q.rdat;
    assign msg_mode = r_q.page[PG_MSG];

    assert_slot_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_re || cml_re || cml_we || cmh_re || cmh_we) |-> svc_slot);

    assert_one_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dm_re, cml_re, cml_we, cmh_re, cmh_we}));

    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && sel_act) |=> !ack_n);

    assert_oe_in_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !ack_n);

    assert_fast_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && sel_act && !addr[ADDR_W-1] && !rw) |=> !ack_n);

    assert_split_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode === msg_mode && r_q.page[PG_SPLIT] |-> !(cmh_we || cmh_re));
endmodule

// File: tb/mpi_paged_port_bench.sv
`timescale 1ns/1ps
module mpi_paged_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe, ack_n, msg_mode;
    logic       svc_slot;
    logic [7:0] mem_addr, mem_wdata;
    logic       dm_re, cml_re, cml_we, cmh_re, cmh_we;
    logic [7:0] dm_rdata = '0, cml_rdata = '0;
    logic [2:0] cmh_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mpi_paged_port u_mpi_paged_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
        .msg_mode(msg_mode), .svc_slot(svc_slot), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dm_re(dm_re), .dm_rdata(dm_rdata),
        .cml_re(cml_re), .cml_we(cml_we), .cml_rdata(cml_rdata),
        .cmh_re(cmh_re), .cmh_we(cmh_we), .cmh_rdata(cmh_rdata)
    );

    // Slot generator and array models
    logic [2:0] slot_cnt = '0;
    logic [7:0] cml_mem [256];
    logic [2:0] cmh_mem [256];
    assign svc_slot = (slot_cnt == 3'd5);

    initial begin
        for (int i = 0; i < 256; i++) begin
            cml_mem[i] = 8'h00;
            cmh_mem[i] = 3'b000;
        end
    end

    always @(posedge clk) begin
        slot_cnt <= slot_cnt + 3'd1;
        if (dm_re)  dm_rdata  <= mem_addr ^ 8'h5A;
        if (cml_re) cml_rdata <= cml_mem[mem_addr];
        if (cmh_re) cmh_rdata <= cmh_mem[mem_addr];
        if (cml_we) cml_mem[mem_addr] <= mem_wdata;
        if (cmh_we) cmh_mem[mem_addr] <= mem_wdata[2:0];
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic is_rd, input logic [5:0] a, input logic [7:0] d,
                          output logic [7:0] val, output logic oe, output int lat);
        @(negedge clk);
        addr = a; rw = is_rd; wdata = d; cs_n = 1'b0; ds = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (ack_n && lat < 200);
        val = rdata;
        oe  = rdata_oe;
        ds = 1'b0; cs_n = 1'b1;
        for (int k = 0; k < 50 && !ack_n; k++) @(negedge clk);
    endtask

    // {read, addr, wdata, expected read data}
    localparam logic [22:0] VEC [28] = '{
        {1'b0, 6'h00, 8'h12, 8'h00},  // page: low store, stream 2
        {1'b0, 6'h25, 8'hA5, 8'h00},
        {1'b0, 6'h1F, 8'h13, 8'h00},  // R1 page via addr 0x1F: stream 3
        {1'b0, 6'h25, 8'h3C, 8'h00},
        {1'b1, 6'h25, 8'h00, 8'h3C},  // R2
        {1'b0, 6'h00, 8'h12, 8'h00},
        {1'b1, 6'h25, 8'h00, 8'hA5},  // R2 other stream kept apart
        {1'b1, 6'h0A, 8'h00, 8'h12},  // R1 page read via addr 0x0A
        {1'b0, 6'h00, 8'h1A, 8'h00},  // high store, stream 2
        {1'b0, 6'h25, 8'hFF, 8'h00},
        {1'b1, 6'h25, 8'h00, 8'h07},  // R3
        {1'b0, 6'h00, 8'h0A, 8'h00},  // sample store, stream 2
        {1'b1, 6'h26, 8'h00, 8'h1C},  // R2 sample 0x46^0x5A
        {1'b0, 6'h26, 8'h00, 8'h00},  // R5 write ignored
        {1'b1, 6'h26, 8'h00, 8'h1C},  // R5
        {1'b0, 6'h00, 8'h02, 8'h00},  // select code 00
        {1'b0, 6'h21, 8'h77, 8'h00},
        {1'b1, 6'h21, 8'h00, 8'h00},  // R5
        {1'b0, 6'h00, 8'h9A, 8'h00},  // split, select high, stream 2
        {1'b0, 6'h27, 8'h5E, 8'h00},  // R4 goes to low store
        {1'b1, 6'h27, 8'h00, 8'h1D},  // R4 read from sample store
        {1'b1, 6'h00, 8'h00, 8'h9A},  // R1
        {1'b0, 6'h00, 8'h12, 8'h00},
        {1'b1, 6'h27, 8'h00, 8'h5E},  // R4 low store got the split write
        {1'b0, 6'h00, 8'h1A, 8'h00},
        {1'b1, 6'h27, 8'h00, 8'h00},  // R4 high store untouched
        {1'b0, 6'h00, 8'h7F, 8'h00},  // bit 5 dropped
        {1'b1, 6'h00, 8'h00, 8'h5F}   // R1
    };

    initial begin
        logic [7:0] v;
        logic       oe;
        int         lat, lat_pg, lat_mem;

        repeat (4) @(negedge clk);
        // R10 reset state
        check(ack_n == 1'b1, "R10 ack_n", ack_n, 1);
        check(rdata_oe == 1'b0, "R10 rdata_oe", rdata_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(msg_mode == 1'b0, "R10 msg_mode", msg_mode, 0);
        access(1'b1, 6'h00, 8'h00, v, oe, lat);
        check(v == 8'h00, "R10 page after reset", v, 0);

        for (int i = 0; i < 28; i++) begin
            access(VEC[i][22], VEC[i][21:16], VEC[i][15:8], v, oe, lat);
            if (VEC[i][22])
                check(v == VEC[i][7:0], $sformatf("R1-tagged vector %0d data", i), v, VEC[i][7:0]);
            check(lat < 200, "R9 vector acknowledged", lat, 0);
        end
        check(msg_mode == 1'b1, "R1 msg_mode set", msg_mode, 1);

        // R7 latency: page write fast, array access slow
        access(1'b0, 6'h00, 8'h12, v, oe, lat_pg);
        check(lat_pg <= 4, "R7 page write latency", lat_pg, 4);
        check(msg_mode == 1'b0, "R1 msg_mode cleared", msg_mode, 0);
        access(1'b0, 6'h30, 8'h44, v, oe, lat_mem);
        check(lat_mem >= 5, "R7 array write latency", lat_mem, 5);
        check(oe == 1'b0, "R9 no drive on write ack", oe, 0);
        access(1'b1, 6'h30, 8'h00, v, oe, lat);
        check(oe == 1'b1, "R9 drive on read ack", oe, 1);
        check(v == 8'h44, "R2 readback ch16", v, 8'h44);
        check(lat >= 5, "R7 array read latency", lat, 5);

        // R6: strobe with chip select high is ignored
        @(negedge clk);
        addr = 6'h00; rw = 1'b0; wdata = 8'hFF; cs_n = 1'b1; ds = 1'b1;
        lat = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!ack_n) lat++;
        end
        ds = 1'b0;
        check(lat == 0, "R6 cs_n high no ack", lat, 0);
        // R6: chip select without strobe is ignored
        cs_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!ack_n) lat++;
        end
        cs_n = 1'b1;
        check(lat == 0, "R6 ds low no ack", lat, 0);
        access(1'b1, 6'h00, 8'h00, v, oe, lat);
        check(v == 8'h12, "R6 page unchanged", v, 8'h12);

        // R9: acknowledge held while strobes stay active
        @(negedge clk);
        addr = 6'h25; rw = 1'b1; cs_n = 1'b0; ds = 1'b1;
        lat = 0;
        while (ack_n && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ack_n) lat++;
        end
        check(lat == 0, "R9 ack held", lat, 0);
        ds = 1'b0;
        lat = 0;
        while (!ack_n && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        cs_n = 1'b1;
        check(ack_n == 1'b1 && lat <= 4, "R9 ack released", lat, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule